// File: doc/BRIEF.md
# PWM Pattern Buffer Transfer Controller

This block sits between the software-visible pattern buffers of a three-phase PWM generator and its working output shift register. Software writes the next switching pattern into a pair of buffers, and the controller decides when the pair is copied into the working register. It also decides when the dead-time timers are started. A copy is requested by a transfer trigger. Three sources raise a transfer trigger: the carrier counter underflowing, software writing 1 to a trigger bit, or software writing the carrier period register while the period-write trigger is enabled.

Two modulation modes are supported. In triangular mode a written pattern is copied once, on the first trigger after it was written, and later triggers leave the working register alone until new data arrives. In sawtooth mode every trigger copies the buffers and also starts the dead-time timers. In both modes the falling edge of any of three one-shot timer pulses starts the dead-time timers. A configuration check flags sawtooth mode combined with the alternate three-phase mode or with reload control.

Top module: `pwm_xfer_ctrl`

## Requirements
- R1: A transfer trigger is an underflow pulse, a software trigger write carrying data 1, or a period write while `period_trig_en` is 1. A software trigger write carrying data 0 and a period write with `period_trig_en` at 0 are ignored. A caused `load_stb` or `dt_trig` is high in the clock cycle after the cycle of its cause.
- R2: In triangular mode (`saw_mode` = 0) a trigger produces `load_stb` only if at least one buffer is pending, and that transfer clears every pending flag. A second trigger with no new write produces no load.
- R3: In sawtooth mode (`saw_mode` = 1) every transfer trigger produces `load_stb`, whether or not a buffer is pending.
- R4: A falling edge (1 then 0 on consecutive clocks) on any bit of `os_pulse` produces `dt_trig` in either mode.
- R5: In sawtooth mode every transfer trigger, including a software trigger write, also produces `dt_trig`. In triangular mode a transfer trigger alone produces no `dt_trig`.
- R6: `sw_trig_rd` reads 0 at all times.
- R7: `cfg_err` is 1 exactly when `saw_mode` is 1 and either `alt_mode` or `reload_ctl` is 1. The check is combinational.
- R8: Trigger sources that coincide in one clock cycle produce one single-cycle `load_stb`.
- R9: `load_data` carries buffer 0 in bits [PAT_W-1:0] and buffer 1 in the bits above. It takes the buffer contents held before the trigger cycle and holds them between loads. A buffer written in the same cycle as a trigger keeps its old contents for that transfer and remains pending.
- R10: After reset `load_stb`, `dt_trig` and `load_data` are 0 and no buffer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_wr | input | NUM_BUF | Per-buffer write strobe |
| buf_wdata | input | NUM_BUF*PAT_W | Write data, buffer 0 in the low bits |
| carrier_uflow | input | 1 | Carrier counter underflow pulse |
| sw_trig_wr | input | 1 | Write strobe of the software trigger bit |
| sw_trig_wdata | input | 1 | Data written to the software trigger bit |
| period_wr | input | 1 | Write strobe of the carrier period register |
| period_trig_en | input | 1 | Enables period writes as a trigger source |
| os_pulse | input | NUM_OS | One-shot timer pulse levels |
| saw_mode | input | 1 | 0 triangular, 1 sawtooth modulation |
| alt_mode | input | 1 | Alternate three-phase mode bit |
| reload_ctl | input | 1 | Carrier reload control bit |
| load_stb | output | 1 | Working register load strobe |
| load_data | output | NUM_BUF*PAT_W | Working register contents |
| dt_trig | output | 1 | Dead-time timer start pulse |
| sw_trig_rd | output | 1 | Read-back value of the software trigger bit |
| cfg_err | output | 1 | Invalid configuration for sawtooth mode |

## Verification
The assertions check the following on every cycle:
- each load has a trigger one cycle before it;
- a sawtooth trigger is always followed by a load and a dead-time pulse;
- a one-shot falling edge is always followed by a dead-time pulse;
- a triangular trigger with nothing pending causes no load;
- a buffer write leaves the buffer pending with the new data;
- a triangular transfer clears the flags.

The bench's scenarios cover the rest:
- that ignored writes really stay silent;
- that a second triangular trigger does not reload;
- that coinciding sources merge into one strobe;
- that a write in the trigger cycle is deferred with the right data on the pins;
- the full configuration error table.

// File: rtl/pwm_xfer_pkg.sv
// Package: shared types for the PWM pattern transfer controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_xfer_pkg;
    typedef enum logic {
        MOD_TRI = 1'b0,
        MOD_SAW = 1'b1
    } mod_mode_e;

    // Returns 1 when the mode bit selects sawtooth modulation.
    function automatic logic is_saw(input logic mode_bit);
        return mod_mode_e'(mode_bit) == MOD_SAW;
    endfunction
endpackage

// File: rtl/xfer_trig_merge.sv
// Module: merges the transfer trigger sources and detects one-shot falling edges.
// Assumes: all inputs are synchronous to clk; os_pulse levels are registered upstream.
module xfer_trig_merge #(
    parameter int NUM_OS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_uflow,
    input  logic              sw_trig_wr,
    input  logic              sw_trig_wdata,
    input  logic              period_wr,
    input  logic              period_trig_en,
    input  logic [NUM_OS-1:0] os_pulse,
    output logic              xtrig,
    output logic [NUM_OS-1:0] os_fall
);
    logic [NUM_OS-1:0] os_prev;

    // Combines the three trigger sources into one per-cycle request.
    always_comb begin
        xtrig = carrier_uflow
              | (sw_trig_wr & sw_trig_wdata)
              | (period_wr & period_trig_en);
    end

    // Remembers last cycle's one-shot levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) os_prev <= '0;
        else        os_prev <= os_pulse;
    end

    // Flags a high-to-low change on each one-shot line.
    always_comb begin
        os_fall = os_prev & ~os_pulse;
    end
endmodule

// File: rtl/xfer_pat_buf.sv
// Module: one pattern buffer with its pending flag.
// Assumes: a write in the same cycle as a clear wins, so the new data stays pending.
module xfer_pat_buf #(
    parameter int PAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PAT_W-1:0] wdata,
    input  logic             clr,
    output logic [PAT_W-1:0] pat,
    output logic             pend
);
    // Captures written data and tracks whether it still awaits transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat  <= '0;
            pend <= 1'b0;
        end else if (wr) begin
            pat  <= wdata;
            pend <= 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !wr |=> !pend); // R2
    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> pend && pat == $past(wdata)); // R9
endmodule

// File: rtl/xfer_out_stage.sv
// Module: registers the load strobe, working pattern and dead-time trigger.
// Assumes: pat_bus holds buffer contents from before the current cycle's writes.
module xfer_out_stage #(
    parameter int NUM_BUF = 2,
    parameter int PAT_W   = 6,
    parameter int NUM_OS  = 3,
    localparam int DATA_W = NUM_BUF * PAT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xtrig,
    input  logic                          saw,
    input  logic                          any_pend,
    input  logic [NUM_OS-1:0]             os_fall,
    input  logic [NUM_BUF-1:0][PAT_W-1:0] pat_bus,
    output logic                          load_stb,
    output logic [DATA_W-1:0]             load_data,
    output logic                          dt_trig
);
    logic do_load;
    logic do_dt;

    // Decides whether this cycle's trigger copies the buffers.
    always_comb begin
        do_load = xtrig && (saw || any_pend);
    end

    // Decides whether the dead-time timers start.
    always_comb begin
        do_dt = (|os_fall) || (saw && xtrig);
    end

    // Registers the strobe and pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb <= 1'b0;
            dt_trig  <= 1'b0;
        end else begin
            load_stb <= do_load;
            dt_trig  <= do_dt;
        end
    end

    // Copies the buffer pair into the working register on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_data <= '0;
        else if (do_load) load_data <= pat_bus;
    end

    AST_LOAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(xtrig)); // R1
    AST_SAW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        saw && xtrig |=> load_stb); // R3
    AST_SAW_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
        saw && xtrig |=> dt_trig); // R5
    AST_FALL_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
        (|os_fall) |=> dt_trig); // R4
endmodule

// File: rtl/pwm_xfer_ctrl.sv
// Module: top of the PWM pattern transfer controller. It moves the buffered
// pattern pair into the working register and issues dead-time triggers.
// Assumes: synchronous inputs; write strobes are single-cycle.
module pwm_xfer_ctrl #(
    parameter int NUM_BUF = 2,
    parameter int PAT_W   = 6,
    parameter int NUM_OS  = 3,
    localparam int DATA_W = NUM_BUF * PAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] buf_wr,
    input  logic [DATA_W-1:0]  buf_wdata,
    input  logic               carrier_uflow,
    input  logic               sw_trig_wr,
    input  logic               sw_trig_wdata,
    input  logic               period_wr,
    input  logic               period_trig_en,
    input  logic [NUM_OS-1:0]  os_pulse,
    input  logic               saw_mode,
    input  logic               alt_mode,
    input  logic               reload_ctl,
    output logic               load_stb,
    output logic [DATA_W-1:0]  load_data,
    output logic               dt_trig,
    output logic               sw_trig_rd,
    output logic               cfg_err
);
    import pwm_xfer_pkg::*;

    logic                          xtrig;
    logic [NUM_OS-1:0]             os_fall;
    logic                          saw;
    logic                          any_pend;
    logic                          tri_clr;
    logic [NUM_BUF-1:0]            pend_vec;
    logic [NUM_BUF-1:0][PAT_W-1:0] pat_bus;

    // Decodes the modulation mode.
    always_comb saw = is_saw(saw_mode);

    // Flags that any buffer still awaits transfer.
    always_comb any_pend = |pend_vec;

    // A triangular-mode transfer consumes all pending data.
    always_comb tri_clr = !saw && xtrig && any_pend;

    // Sawtooth mode is invalid with the alternate mode or reload control.
    always_comb cfg_err = saw && (alt_mode || reload_ctl);

    // The trigger bit is write-only.
    always_comb sw_trig_rd = 1'b0;

    xfer_trig_merge #(.NUM_OS(NUM_OS)) u_trig (
        .clk            (clk),
        .rst_n          (rst_n),
        .carrier_uflow  (carrier_uflow),
        .sw_trig_wr     (sw_trig_wr),
        .sw_trig_wdata  (sw_trig_wdata),
        .period_wr      (period_wr),
        .period_trig_en (period_trig_en),
        .os_pulse       (os_pulse),
        .xtrig          (xtrig),
        .os_fall        (os_fall)
    );

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        xfer_pat_buf #(.PAT_W(PAT_W)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (buf_wr[b]),
            .wdata (buf_wdata[b*PAT_W +: PAT_W]),
            .clr   (tri_clr),
            .pat   (pat_bus[b]),
            .pend  (pend_vec[b])
        );
    end

    xfer_out_stage #(.NUM_BUF(NUM_BUF), .PAT_W(PAT_W), .NUM_OS(NUM_OS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtrig     (xtrig),
        .saw       (saw),
        .any_pend  (any_pend),
        .os_fall   (os_fall),
        .pat_bus   (pat_bus),
        .load_stb  (load_stb),
        .load_data (load_data),
        .dt_trig   (dt_trig)
    );

    AST_TRI_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !saw_mode && xtrig && !any_pend |=> !load_stb); // R2
    AST_ERR_ONLY_SAW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> saw_mode); // R7
endmodule

// File: tb/test_pwm_xfer_ctrl.sv
module test_pwm_xfer_ctrl;
    localparam int NB = 2;
    localparam int PW = 6;
    localparam int NO = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic [NB-1:0]    buf_wr;
    logic [NB*PW-1:0] buf_wdata;
    logic             carrier_uflow, sw_trig_wr, sw_trig_wdata, period_wr, period_trig_en;
    logic [NO-1:0]    os_pulse;
    logic             saw_mode, alt_mode, reload_ctl;
    logic             load_stb, dt_trig, sw_trig_rd, cfg_err;
    logic [NB*PW-1:0] load_data;

    pwm_xfer_ctrl #(.NUM_BUF(NB), .PAT_W(PW), .NUM_OS(NO)) i_pwm_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .carrier_uflow(carrier_uflow), .sw_trig_wr(sw_trig_wr), .sw_trig_wdata(sw_trig_wdata),
        .period_wr(period_wr), .period_trig_en(period_trig_en), .os_pulse(os_pulse),
        .saw_mode(saw_mode), .alt_mode(alt_mode), .reload_ctl(reload_ctl),
        .load_stb(load_stb), .load_data(load_data), .dt_trig(dt_trig),
        .sw_trig_rd(sw_trig_rd), .cfg_err(cfg_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string scen = "R10";
    bit    done = 0;
    bit    started = 0;
    int    n_loads = 0;

    // Behavioural reference model
    int mbuf [NB];
    bit mpend [NB];
    bit [NO-1:0] mos_prev;
    bit exp_load, exp_dt;
    longint exp_data;

    always @(posedge clk) begin
        bit xt, anyp, fall;
        started = 1;
        if (!rst_n) begin
            foreach (mbuf[i]) begin mbuf[i] = 0; mpend[i] = 0; end
            mos_prev = '0; exp_load = 0; exp_dt = 0; exp_data = 0;
        end else begin
            xt = carrier_uflow || (sw_trig_wr && sw_trig_wdata) || (period_wr && period_trig_en);
            anyp = 0;
            foreach (mpend[i]) if (mpend[i]) anyp = 1;
            fall = 0;
            for (int k = 0; k < NO; k++) if (mos_prev[k] && !os_pulse[k]) fall = 1;
            exp_load = xt && (saw_mode || anyp);
            if (exp_load) begin
                exp_data = 0;
                for (int b = 0; b < NB; b++) exp_data += longint'(mbuf[b]) << (b * PW);
            end
            exp_dt = fall || (saw_mode && xt);
            for (int b = 0; b < NB; b++) begin
                if (buf_wr[b]) begin
                    mbuf[b] = int'(buf_wdata[b*PW +: PW]);
                    mpend[b] = 1;
                end else if (!saw_mode && xt && anyp) begin
                    mpend[b] = 0;
                end
            end
            mos_prev = os_pulse;
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(scen, "load_stb", longint'(load_stb), longint'(exp_load));
            chk(scen, "load_data", longint'(load_data), exp_data);
            chk(scen, "dt_trig", longint'(dt_trig), longint'(exp_dt));
            chk("R6", "sw_trig_rd", longint'(sw_trig_rd), 0);
            chk("R7", "cfg_err", longint'(cfg_err), longint'(saw_mode && (alt_mode || reload_ctl)));
            if (load_stb) n_loads++;
        end
    end

    task automatic idle();
        buf_wr = '0; carrier_uflow = 0; sw_trig_wr = 0; sw_trig_wdata = 0; period_wr = 0;
    endtask

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
        idle();
    endtask

    task automatic wr_bufs(logic [NB-1:0] m, logic [PW-1:0] d0, logic [PW-1:0] d1);
        buf_wr = m; buf_wdata = {d1, d0};
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int l0;
        rst_n = 0; idle(); buf_wdata = '0; period_trig_en = 0; os_pulse = '0;
        saw_mode = 0; alt_mode = 0; reload_ctl = 0;
        step(3);
        rst_n = 1;
        // R10: a trigger right after reset finds nothing pending
        scen = "R10"; carrier_uflow = 1; step(3);
        // R2: one transfer per written pattern
        scen = "R2"; wr_bufs(2'b11, 6'h05, 6'h09); step();
        carrier_uflow = 1; step(2);
        carrier_uflow = 1; step(2);
        wr_bufs(2'b01, 6'h2a, 6'h00); step();
        carrier_uflow = 1; step(2);
        // R1: ignored writes, then valid software and period triggers
        scen = "R1"; wr_bufs(2'b10, 6'h00, 6'h33); step();
        period_wr = 1; step();
        sw_trig_wr = 1; sw_trig_wdata = 0; step(2);
        l0 = n_loads;
        period_trig_en = 1; period_wr = 1; step(3);
        chk("R1", "period trigger loads", n_loads - l0, 1);
        wr_bufs(2'b01, 6'h11, 6'h00); step();
        sw_trig_wr = 1; sw_trig_wdata = 1; step(2);
        // R9: a write in the trigger cycle is deferred
        scen = "R9"; wr_bufs(2'b11, 6'h01, 6'h02); step();
        wr_bufs(2'b01, 6'h3f, 6'h02); carrier_uflow = 1; step(2);
        carrier_uflow = 1; step(2);
        // R8: coinciding sources give one strobe
        scen = "R8"; wr_bufs(2'b11, 6'h07, 6'h08); step();
        l0 = n_loads;
        carrier_uflow = 1; sw_trig_wr = 1; sw_trig_wdata = 1; period_wr = 1; step(3);
        chk("R8", "single load", n_loads - l0, 1);
        // R3 and R5: sawtooth reloads and starts dead time on every trigger
        scen = "R3"; saw_mode = 1; step();
        for (int i = 0; i < 4; i++) begin carrier_uflow = 1; step(); end
        step();
        scen = "R5"; sw_trig_wr = 1; sw_trig_wdata = 1; step(2);
        wr_bufs(2'b10, 6'h00, 6'h15); step();
        carrier_uflow = 1; step(2);
        // R4: one-shot falling edges in both modes
        scen = "R4";
        for (int k = 0; k < NO; k++) begin
            os_pulse[k] = 1; step(2); os_pulse[k] = 0; step(2);
        end
        saw_mode = 0; os_pulse = 3'b101; step(); os_pulse = 3'b000; step(2);
        carrier_uflow = 1; step(2);
        // R7: configuration error table
        scen = "R7";
        for (int m = 0; m < 8; m++) begin
            saw_mode = m[0]; alt_mode = m[1]; reload_ctl = m[2]; step();
        end
        alt_mode = 0; reload_ctl = 0;
        // Mixed random traffic, compared every cycle
        scen = "R1";
        for (int i = 0; i < 400; i++) begin
            buf_wr = NB'($urandom_range(0, 3) == 0 ? $urandom : 0);
            buf_wdata = (NB*PW)'($urandom);
            carrier_uflow = ($urandom_range(0, 3) == 0);
            sw_trig_wr = ($urandom_range(0, 5) == 0); sw_trig_wdata = 1'($urandom);
            period_wr = ($urandom_range(0, 5) == 0); period_trig_en = 1'($urandom);
            os_pulse = NO'($urandom);
            if (i % 50 == 0) saw_mode = ~saw_mode;
            @(posedge clk); #1;
        end
        idle(); step(2);
        finish_run();
    end
endmodule